// File: doc/BRIEF.md
# Flash Write-Protection Controller

This block decides whether write requests to a 131,072-byte serial flash may proceed. A command decoder in front of it sends one-cycle strobes. Two of them set and clear a write-enable latch. The other three request a status write, a sector erase at a 17-bit address, or a page program given as a start address and a byte count. For each status write, erase or program request, the block answers with a grant pulse or a deny pulse. It takes into account the write-enable latch, the two block-protect bits, the protect-enable bit and the level of the active-low write-protect pin. It also refuses writes while the array engine reports busy.

The block keeps the status byte that software reads back. A granted status write does not change the protection at once. It starts an internal write cycle of a parameterised length. The protect pin is sampled only when that cycle starts, so a later change on the pin cannot abort the cycle. The new block-protect and protect-enable values take effect when the cycle ends. Array contents and the timing of array operations belong to other blocks. This block only sees the busy level they produce.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `status_o` is 8'h00 and `grant_o` and `deny_o` are low.
- R2: A `wel_set_i` strobe makes `status_o[1]` read 1 and a `wel_clr_i` strobe makes it read 0, one clock edge later. Both strobes are ignored while `busy_i` is high or a status write cycle is in progress.
- R3: Every status write, erase or program request produces exactly one of `grant_o` or `deny_o`, high for one cycle, on the edge that samples the request. On that same edge the write-enable latch is cleared, whether the request was granted or refused.
- R4: A write request made while `status_o[1]` is 0 is denied.
- R5: A write request is denied while `busy_i` is high or a status write cycle is in progress. `status_o[0]` reads 1 one edge after either condition begins and reads 0 one edge after both have ended.
- R6: `status_o[3:2]` selects the protected range. 00 protects nothing, 01 protects 0x18000–0x1FFFF, 10 protects 0x10000–0x1FFFF and 11 protects the whole array. An erase or program whose address falls in the protected range is denied.
- R7: A program request is denied unless `prog_len_i` is 1 to 256 and the low 8 bits of the address plus `prog_len_i` do not exceed 256, so that the request stays inside one 256-byte page.
- R8: When `status_o[7]` is 1 and `wp_n_i` is low, status writes are denied. When `status_o[7]` is 0, `wp_n_i` has no effect.
- R9: A granted status write copies `sr_data_i[3:2]` into `status_o[3:2]` and `sr_data_i[7]` into `status_o[7]` exactly SR_WRITE_CYCLES edges after the grant. The other data bits are ignored and `status_o[6:4]` always reads 0. A change on `wp_n_i` during the cycle does not abort it.
- R10: When several strobes arrive in the same cycle, only one of them is acted on. The order, from highest to lowest, is: `wel_clr_i`, `wel_set_i`, `sr_wr_i`, `erase_i`, `prog_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | Write-protect pin level, active low |
| busy_i | input | 1 | Array engine busy |
| wel_set_i | input | 1 | Strobe: set write-enable latch |
| wel_clr_i | input | 1 | Strobe: clear write-enable latch |
| sr_wr_i | input | 1 | Strobe: status write request |
| sr_data_i | input | 8 | Data for the status write |
| erase_i | input | 1 | Strobe: sector erase request |
| prog_i | input | 1 | Strobe: page program request |
| addr_i | input | ADDR_W (17) | Byte address for erase or program |
| prog_len_i | input | PAGE_W+1 (9) | Program byte count |
| grant_o | output | 1 | Request granted pulse |
| deny_o | output | 1 | Request refused pulse |
| status_o | output | 8 | Status byte |

## Verification
Grant and deny pulses, the write-enable bit and the busy bit are all due one edge after the request or busy change that causes them. The committed protection bits are due SR_WRITE_CYCLES edges after the grant of a status write. The bench drives each input set on a falling edge and holds it for one full cycle. It compares every output on the following falling edge against a per-cycle model. That model advances its own write-cycle countdown in the same edge steps. Directed sequences also check the protection bits explicitly after the counted wait, and they probe the protect pin during a write cycle that is already running.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  typedef enum logic [2:0] {
    REQ_NONE    = 3'd0,
    REQ_PROG    = 3'd1,
    REQ_ERASE   = 3'd2,
    REQ_SR_WR   = 3'd3,
    REQ_WEL_SET = 3'd4,
    REQ_WEL_CLR = 3'd5
  } req_kind_e;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_mode_e;

  localparam int NUM_STROBES = 5;

  // strobe index 0 is lowest priority, index NUM_STROBES-1 highest
  function automatic req_kind_e strobe_kind(input int idx);
    case (idx)
      0:       return REQ_PROG;
      1:       return REQ_ERASE;
      2:       return REQ_SR_WR;
      3:       return REQ_WEL_SET;
      4:       return REQ_WEL_CLR;
      default: return REQ_NONE;
    endcase
  endfunction

  function automatic logic is_write(input req_kind_e k);
    return (k == REQ_PROG) || (k == REQ_ERASE) || (k == REQ_SR_WR);
  endfunction

endpackage

// File: rtl/fwp_req_arbiter.sv
module fwp_req_arbiter
  import fwp_pkg::*;
(
  input  logic      wel_clr_i,
  input  logic      wel_set_i,
  input  logic      sr_wr_i,
  input  logic      erase_i,
  input  logic      prog_i,
  output req_kind_e kind_o
);

  logic [NUM_STROBES-1:0] strobes;
  assign strobes = {wel_clr_i, wel_set_i, sr_wr_i, erase_i, prog_i};

  // later (higher) indices override earlier ones: R10
  always_comb begin
    kind_o = REQ_NONE;
    for (int i = 0; i < NUM_STROBES; i++) begin
      if (strobes[i]) kind_o = strobe_kind(i);
    end
  end

  always_comb begin
    AST_ARB_ONE_WINNER: assert (strobes == '0 || kind_o != REQ_NONE); // R10
  end

endmodule

// File: rtl/fwp_region_check.sv
module fwp_region_check
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);

  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QUARTER_BASE = HALF_BASE + (HALF_BASE >> 1);

  always_comb begin
    case (bp_mode_e'(bp_i))
      BP_NONE:    prot_o = 1'b0;
      BP_QUARTER: prot_o = (addr_i >= QUARTER_BASE);
      BP_HALF:    prot_o = (addr_i >= HALF_BASE);
      default:    prot_o = 1'b1;
    endcase
  end

  always_comb begin
    AST_REGION_NESTED: assert (!(bp_i == 2'b01 && prot_o) || addr_i >= HALF_BASE); // R6
  end

endmodule

// File: rtl/fwp_page_check.sv
module fwp_page_check #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] offset_i,
  input  logic [PAGE_W:0]   len_i,
  output logic              ok_o
);

  localparam int SUM_W = PAGE_W + 2;
  localparam logic [SUM_W-1:0] PAGE_BYTES = SUM_W'(1) << PAGE_W;

  logic [SUM_W-1:0] end_pos;

  assign end_pos = {2'b00, offset_i} + {1'b0, len_i};
  assign ok_o    = (len_i != '0) && (end_pos <= PAGE_BYTES);

  always_comb begin
    AST_PAGE_LEN_NONZERO: assert (!ok_o || len_i != '0); // R7
  end

endmodule

// File: rtl/fwp_status_reg.sv
module fwp_status_reg
  import fwp_pkg::*;
#(
  parameter int SR_WRITE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  req_kind_e  kind_i,
  input  logic       busy_i,
  input  logic       sr_start_i,
  input  logic [1:0] sr_bp_i,
  input  logic       sr_wpen_i,
  output logic       wel_o,
  output logic [1:0] bp_o,
  output logic       wpen_o,
  output logic       sr_active_o,
  output logic [7:0] status_o
);

  localparam int CNT_W = $clog2(SR_WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SR_WRITE_CYCLES);

  logic             wel_q, wel_d;
  logic [1:0]       bp_q, bp_d, pend_bp_q, pend_bp_d;
  logic             wpen_q, wpen_d, pend_wpen_q, pend_wpen_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_any;

  assign sr_active_o = (cnt_q != '0);
  assign busy_any    = busy_i | sr_active_o;

  always_comb begin
    wel_d = wel_q;
    case (kind_i)
      REQ_WEL_SET: if (!busy_any) wel_d = 1'b1;
      REQ_WEL_CLR: if (!busy_any) wel_d = 1'b0;
      REQ_SR_WR, REQ_ERASE, REQ_PROG: wel_d = 1'b0;
      default: wel_d = wel_q;
    endcase
  end

  always_comb begin
    cnt_d       = cnt_q;
    bp_d        = bp_q;
    wpen_d      = wpen_q;
    pend_bp_d   = pend_bp_q;
    pend_wpen_d = pend_wpen_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        bp_d   = pend_bp_q;
        wpen_d = pend_wpen_q;
      end
    end else if (sr_start_i) begin
      cnt_d       = CNT_LOAD;
      pend_bp_d   = sr_bp_i;
      pend_wpen_d = sr_wpen_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q       <= 1'b0;
      bp_q        <= 2'b00;
      wpen_q      <= 1'b0;
      pend_bp_q   <= 2'b00;
      pend_wpen_q <= 1'b0;
      cnt_q       <= '0;
      status_o    <= 8'h00;
    end else begin
      wel_q       <= wel_d;
      bp_q        <= bp_d;
      wpen_q      <= wpen_d;
      pend_bp_q   <= pend_bp_d;
      pend_wpen_q <= pend_wpen_d;
      cnt_q       <= cnt_d;
      status_o    <= {wpen_d, 3'b000, bp_d, wel_d, busy_i | (cnt_d != '0)};
    end
  end

  assign wel_o  = wel_q;
  assign bp_o   = bp_q;
  assign wpen_o = wpen_q;

  AST_SR_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LOAD); // R9
  AST_SR_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > CNT_W'(1)) |=> ($stable(bp_q) && $stable(wpen_q))); // R9
  AST_WEL_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    is_write(kind_i) |=> !wel_q); // R3
  AST_WEL_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    ((kind_i == REQ_WEL_SET || kind_i == REQ_WEL_CLR) && busy_any) |=> $stable(wel_q)); // R2

endmodule

// File: rtl/fwp_decide.sv
module fwp_decide
  import fwp_pkg::*;
(
  input  req_kind_e kind_i,
  input  logic      wel_i,
  input  logic      busy_any_i,
  input  logic      wpen_i,
  input  logic      wp_n_i,
  input  logic      prot_i,
  input  logic      len_ok_i,
  output logic      grant_o,
  output logic      deny_o
);

  logic allowed;

  always_comb begin
    allowed = 1'b0;
    if (!busy_any_i && wel_i) begin
      case (kind_i)
        REQ_SR_WR: allowed = !(wpen_i && !wp_n_i);
        REQ_ERASE: allowed = !prot_i;
        REQ_PROG:  allowed = !prot_i && len_ok_i;
        default:   allowed = 1'b0;
      endcase
    end
  end

  assign grant_o = is_write(kind_i) && allowed;
  assign deny_o  = is_write(kind_i) && !allowed;

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import fwp_pkg::*;
#(
  parameter int ADDR_W          = 17,
  parameter int PAGE_W          = 8,
  parameter int SR_WRITE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              erase_i,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W:0]   prog_len_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [7:0]        status_o
);

  req_kind_e  kind;
  logic       wel, wpen, sr_active, prot, len_ok;
  logic [1:0] bp;
  logic       grant_d, deny_d;
  logic       unused_sr_bits;

  assign unused_sr_bits = ^{sr_data_i[6:4], sr_data_i[1:0]};

  fwp_req_arbiter u_arb (
    .wel_clr_i (wel_clr_i),
    .wel_set_i (wel_set_i),
    .sr_wr_i   (sr_wr_i),
    .erase_i   (erase_i),
    .prog_i    (prog_i),
    .kind_o    (kind)
  );

  fwp_region_check #(.ADDR_W(ADDR_W)) u_region (
    .bp_i   (bp),
    .addr_i (addr_i),
    .prot_o (prot)
  );

  fwp_page_check #(.PAGE_W(PAGE_W)) u_page (
    .offset_i (addr_i[PAGE_W-1:0]),
    .len_i    (prog_len_i),
    .ok_o     (len_ok)
  );

  fwp_decide u_decide (
    .kind_i     (kind),
    .wel_i      (wel),
    .busy_any_i (busy_i | sr_active),
    .wpen_i     (wpen),
    .wp_n_i     (wp_n_i),
    .prot_i     (prot),
    .len_ok_i   (len_ok),
    .grant_o    (grant_d),
    .deny_o     (deny_d)
  );

  fwp_status_reg #(.SR_WRITE_CYCLES(SR_WRITE_CYCLES)) u_status (
    .clk         (clk),
    .rst         (rst),
    .kind_i      (kind),
    .busy_i      (busy_i),
    .sr_start_i  (grant_d && kind == REQ_SR_WR),
    .sr_bp_i     (sr_data_i[3:2]),
    .sr_wpen_i   (sr_data_i[7]),
    .wel_o       (wel),
    .bp_o        (bp),
    .wpen_o      (wpen),
    .sr_active_o (sr_active),
    .status_o    (status_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      grant_o <= grant_d;
      deny_o  <= deny_d;
    end
  end

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && deny_o)); // R3
  AST_WRITE_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    is_write(kind) |=> (grant_o ^ deny_o)); // R3
  AST_NO_WEL_DENY: assert property (@(posedge clk) disable iff (rst)
    (is_write(kind) && !wel) |=> deny_o); // R4
  AST_BUSY_DENY: assert property (@(posedge clk) disable iff (rst)
    (is_write(kind) && busy_i) |=> deny_o); // R5
  AST_WP_LOCK: assert property (@(posedge clk) disable iff (rst)
    (kind == REQ_SR_WR && wpen && !wp_n_i) |=> deny_o); // R8
  AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    ((kind == REQ_ERASE || kind == REQ_PROG) && bp == 2'b11) |=> !grant_o); // R6
  AST_BAD_LEN_DENY: assert property (@(posedge clk) disable iff (rst)
    (kind == REQ_PROG && !len_ok) |=> deny_o); // R7
  AST_NO_REQ_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !is_write(kind) |=> (!grant_o && !deny_o)); // R10

endmodule

// File: tb/test_flash_wp_ctrl.sv
module test_flash_wp_ctrl;

  localparam int SRW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp_n, busy, set_s, clr_s, sr_s, er_s, pg_s;
  logic [7:0] sdata;
  logic [16:0] addr;
  logic [8:0] plen;
  logic       grant, deny;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;

  // model state
  bit       m_wel, m_wpen, m_pwpen;
  bit [1:0] m_bp, m_pbp;
  int       m_cnt;
  bit       e_grant, e_deny;

  always #2.5 clk = ~clk;

  flash_wp_ctrl #(.ADDR_W(17), .PAGE_W(8), .SR_WRITE_CYCLES(SRW)) i_flash_wp_ctrl (
    .clk(clk), .rst(rst), .wp_n_i(wp_n), .busy_i(busy),
    .wel_set_i(set_s), .wel_clr_i(clr_s), .sr_wr_i(sr_s), .sr_data_i(sdata),
    .erase_i(er_s), .prog_i(pg_s), .addr_i(addr), .prog_len_i(plen),
    .grant_o(grant), .deny_o(deny), .status_o(status)
  );

  function automatic bit f_prot(bit [1:0] bp, bit [16:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 17'h18000;
      2'b10:   return a >= 17'h10000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit f_len_ok(bit [16:0] a, bit [8:0] n);
    return (n != 0) && (int'(a[7:0]) + int'(n) <= 256);
  endfunction

  function automatic bit [7:0] f_status(bit bz);
    return {m_wpen, 3'b000, m_bp, m_wel, bz || (m_cnt != 0)};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock of stimulus; called at a falling edge, checks at the next falling edge
  task automatic step(input bit s, c, w, e, p, input bit [7:0] d, input bit [16:0] a,
                      input bit [8:0] n, input bit wp, bz, input string tag);
    bit busy_any, ok, is_wr;
    set_s = s; clr_s = c; sr_s = w; er_s = e; pg_s = p;
    sdata = d; addr = a; plen = n; wp_n = wp; busy = bz;
    busy_any = bz || (m_cnt != 0);
    e_grant = 0; e_deny = 0;
    is_wr = !c && !s && (w || e || p);
    if (c) begin
      if (!busy_any) m_wel = 0;
    end else if (s) begin
      if (!busy_any) m_wel = 1;
    end else if (is_wr) begin
      if (w)      ok = !(m_wpen && !wp);
      else if (e) ok = !f_prot(m_bp, a);
      else        ok = !f_prot(m_bp, a) && f_len_ok(a, n);
      ok = ok && !busy_any && m_wel;
      e_grant = ok; e_deny = !ok;
      m_wel = 0;
    end
    if (m_cnt != 0) begin
      m_cnt--;
      if (m_cnt == 0) begin m_bp = m_pbp; m_wpen = m_pwpen; end
    end else if (is_wr && w && ok) begin
      m_cnt = SRW; m_pbp = d[3:2]; m_pwpen = d[7];
    end
    @(negedge clk);
    chk(tag, "grant", grant, e_grant);
    chk(tag, "deny", deny, e_deny);
    chk(tag, "status", status, f_status(bz));
  endtask

  task automatic idle(input int cyc, input bit wp, input string tag);
    for (int i = 0; i < cyc; i++) step(0,0,0,0,0, 8'h00, 17'h0, 9'd0, wp, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    set_s = 0; clr_s = 0; sr_s = 0; er_s = 0; pg_s = 0;
    sdata = 0; addr = 0; plen = 0; wp_n = 1; busy = 0;
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", status, 8'h00);
    rst = 0;
    @(negedge clk);
    chk("R1", "status", status, 8'h00);
    chk("R1", "grant", grant, 0);
    chk("R1", "deny", deny, 0);

    // R2 latch set and clear
    step(1,0,0,0,0, 0, 0, 0, 1, 0, "R2");
    chk("R2", "wel set", status[1], 1);
    step(0,1,0,0,0, 0, 0, 0, 1, 0, "R2");
    chk("R2", "wel clr", status[1], 0);

    // R4 no latch
    step(0,0,0,0,1, 0, 17'h00010, 9'd1, 1, 0, "R4");
    chk("R4", "deny no wel", deny, 1);

    // R9 status write with pin toggling mid-cycle
    step(1,0,0,0,0, 0, 0, 0, 1, 0, "R9");
    step(0,0,1,0,0, 8'h8C, 0, 0, 1, 0, "R9");
    chk("R9", "grant sr", grant, 1);
    chk("R5", "busy bit during sr", status[0], 1);
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R2");
    chk("R2", "wel ignored while writing", status[1], 0);
    step(0,0,0,0,1, 0, 17'h0, 9'd1, 0, 0, "R5");
    chk("R5", "deny while writing", deny, 1);
    idle(SRW - 3, 0, "R9");
    chk("R9", "not yet committed", status[3:2], 0);
    idle(1, 0, "R9");
    chk("R9", "committed despite pin", status, 8'h8C);

    // R8 pin lock
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R8");
    step(0,0,1,0,0, 8'h00, 0, 0, 0, 0, "R8");
    chk("R8", "deny locked", deny, 1);

    // R6 quarter protection
    step(1,0,0,0,0, 0, 0, 0, 1, 0, "R8");
    step(0,0,1,0,0, 8'h04, 0, 0, 1, 0, "R8");
    chk("R8", "grant pin high", grant, 1);
    idle(SRW, 1, "R9");
    chk("R6", "bp quarter", status, 8'h04);
    step(1,0,0,0,0, 0, 0, 0, 1, 0, "R6");
    step(0,0,0,1,0, 0, 17'h18000, 0, 1, 0, "R6");
    chk("R6", "erase quarter base", deny, 1);
    step(1,0,0,0,0, 0, 0, 0, 1, 0, "R6");
    step(0,0,0,1,0, 0, 17'h17FFF, 0, 1, 0, "R6");
    chk("R6", "erase below quarter", grant, 1);

    // R8 pin ignored with enable bit clear
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R8");
    step(0,0,1,0,0, 8'h08, 0, 0, 0, 0, "R8");
    chk("R8", "grant pin ignored", grant, 1);
    idle(SRW, 0, "R9");
    chk("R6", "bp half", status, 8'h08);
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R6");
    step(0,0,0,0,1, 0, 17'h10000, 9'd1, 0, 0, "R6");
    chk("R6", "prog half base", deny, 1);
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R6");
    step(0,0,0,0,1, 0, 17'h0FFFF, 9'd1, 0, 0, "R6");
    chk("R6", "prog below half", grant, 1);

    // R7 page bounds
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R7");
    step(0,0,0,0,1, 0, 17'h000F0, 9'd16, 0, 0, "R7");
    chk("R7", "fits page", grant, 1);
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R7");
    step(0,0,0,0,1, 0, 17'h000F0, 9'd17, 0, 0, "R7");
    chk("R7", "crosses page", deny, 1);
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R7");
    step(0,0,0,0,1, 0, 17'h00000, 9'd0, 0, 0, "R7");
    chk("R7", "zero length", deny, 1);
    step(1,0,0,0,0, 0, 0, 0, 0, 0, "R7");
    step(0,0,0,0,1, 0, 17'h00100, 9'd256, 0, 0, "R7");
    chk("R7", "full page", grant, 1);

    // R5 external busy
    step(1,0,0,0,0, 0, 0, 0, 0, 1, "R5");
    chk("R5", "busy status", status, 8'h09);
    step(0,0,0,0,1, 0, 17'h0, 9'd1, 0, 1, "R5");
    chk("R5", "deny busy", deny, 1);
    idle(1, 0, "R5");
    chk("R5", "busy cleared", status[0], 0);

    // R10 priority
    step(1,1,0,0,0, 0, 0, 0, 0, 0, "R10");
    chk("R10", "clear wins", status, 8'h08);
    step(1,0,0,0,1, 0, 17'h0, 9'd1, 0, 0, "R10");
    chk("R10", "set wins over prog", status, 8'h0A);
    chk("R10", "no pulse", grant | deny, 0);
    step(0,0,1,1,0, 8'hFF, 17'h0, 0, 0, 0, "R10");
    chk("R10", "sr wins over erase", grant, 1);
    idle(SRW, 1, "R9");
    chk("R9", "reserved bits ignored", status, 8'h8C);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] r;
      r = $urandom;
      step(r[2:0] == 0, r[5:3] == 0, r[7:6] == 0, r[9:8] == 0, r[11:10] != 0,
           8'($urandom), 17'($urandom), 9'($urandom % 270),
           r[13:12] != 0, r[17:14] == 0, "R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule